// File: doc/BRIEF.md
# Flag-Producing 8-Bit Arithmetic and Logic Unit

This block is the combinational datapath core of a small load/store processor. In a single pass it takes an operation code, two register operands, an immediate byte, a bit index and the current carry flag. It returns the result byte together with new values for the zero (Z), carry (C) and test (T) flags.

Each flag also comes with its own write enable, so the register file updates only the flags that the operation owns. Arithmetic operations write C and Z. Logic and bit-manipulation operations write Z alone. Comparisons and bit tests write T alone and leave both the data result and the other flags untouched. Multiplication and register writeback are handled elsewhere.

The data width `W` is a parameter with a default of 8. Each requirement below is written for that default.

Top module: `alu8_flagged`

## Requirements
- R1: `op_sel` uses these codes: 0 ADD, 1 ADC, 2 SUB, 3 SUC, 4 NEG, 5 INC, 6 DEC, 7 ADI, 8 SUI, 9 OR, 10 AND, 11 XOR, 12 NOT, 13 TOL, 14 BSET, 15 BCLR, 16 BFLIP, 17 BTEST, 18 EQU, 19 SHL0, 20 SHLK.
- R2: ADD computes {C,res} = a + b. ADC computes {C,res} = a + b + carry_in. Both assert `wr_c` and `wr_z`.
- R3: SUB computes {C,res} = a + ((256 - b) mod 256). SUC adds carry_in to the same sum. In both, C is bit 8 of that sum, so subtracting zero never sets C through the negated term. Both assert `wr_c` and `wr_z`.
- R4: ADI computes {C,res} = a + imm. SUI computes {C,res} = a + ((256 - imm) mod 256). Both write C and Z.
- R5: INC computes {C,res} = a + 1. DEC computes {C,res} = a + 255, so C is 1 exactly when a is nonzero. Both write C and Z.
- R6: NEG returns (256 - a) mod 256 and asserts only `wr_z`.
- R7: OR, AND and XOR of a with b, and NOT of a, assert only `wr_z`.
- R8: TOL returns 1 when a is nonzero and 0 otherwise, and asserts only `wr_z`.
- R9: BSET, BCLR and BFLIP set, clear or invert bit `bit_sel` of a, where bit 0 is the LSB. They assert only `wr_z`.
- R10: BTEST drives `flag_t` = a[bit_sel]. EQU drives `flag_t` = (a == b). Both assert only `wr_t` and return `res` = a.
- R11: SHL0 returns {a[6:0],0} and SHLK returns {a[6:0],a[0]}. Both drive C = a[7] and assert `wr_c` and `wr_z`.
- R12: Whenever `wr_z` is high, `flag_z` is 1 exactly when the 8-bit result is zero.
- R13: Codes 21 to 31 return `res` = a and deassert all three write enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code (R1) |
| src_a | input | W | First operand, also the target of unary and bit operations |
| src_b | input | W | Second operand |
| bit_sel | input | log2(W) | Bit index for bit operations |
| imm_val | input | W | Immediate operand |
| carry_in | input | 1 | Current C flag |
| res | output | W | Result byte |
| flag_z | output | 1 | New Z value |
| flag_c | output | 1 | New C value |
| flag_t | output | 1 | New T value |
| wr_z | output | 1 | Z write enable |
| wr_c | output | 1 | C write enable |
| wr_t | output | 1 | T write enable |

## Verification
The bench drives random operands through every operation code, including the unused codes, and adds directed edge cases.

The edge cases target specific mistakes:
- Adding 0xFF and 0x01 catches a carry that is dropped or a Z flag that is computed on nine bits.
- SUB and SUC with b = 0 catch a carry that is derived from an inverted borrow.
- DEC of zero, and NEG of 0x80 and of 0, catch a wrong carry rule or a flag written when it should not be.
- SHLK on values whose LSB is set or clear catches a shift that fills the LSB with zero.
- BCLR down to a zero result catches Z not being updated.

Every vector also compares all three write enables. A design that leaked a flag update into a test or logic operation is reported on that vector.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD   = 5'd0,
      OP_ADC   = 5'd1,
      OP_SUB   = 5'd2,
      OP_SUC   = 5'd3,
      OP_NEG   = 5'd4,
      OP_INC   = 5'd5,
      OP_DEC   = 5'd6,
      OP_ADI   = 5'd7,
      OP_SUI   = 5'd8,
      OP_OR    = 5'd9,
      OP_AND   = 5'd10,
      OP_XOR   = 5'd11,
      OP_NOT   = 5'd12,
      OP_TOL   = 5'd13,
      OP_BSET  = 5'd14,
      OP_BCLR  = 5'd15,
      OP_BFLIP = 5'd16,
      OP_BTEST = 5'd17,
      OP_EQU   = 5'd18,
      OP_SHL0  = 5'd19,
      OP_SHLK  = 5'd20
   } alu_op_e;

   typedef enum logic [1:0] {
      BM_SET  = 2'd0,
      BM_CLR  = 2'd1,
      BM_FLIP = 2'd2
   } bit_mode_e;

   typedef struct packed {
      logic z;
      logic c;
      logic t;
   } flag_en_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] x_in,
   input  logic [W-1:0] y_in,
   input  logic         cin,
   input  logic         neg_y,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W-1:0] y_eff;
   logic [W:0]   total;

   always_comb begin
      y_eff = neg_y ? (~y_in + {{(W-1){1'b0}}, 1'b1}) : y_in;
      total = {1'b0, x_in} + {1'b0, y_eff} + {{W{1'b0}}, cin};
   end

   assign sum  = total[W-1:0];
   assign cout = total[W];
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
   import alu8_pkg::*;
#(
   parameter int W  = 8,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  val,
   input  logic [IW-1:0] idx,
   input  bit_mode_e     mode,
   output logic [W-1:0]  out,
   output logic          picked
);
   logic [W-1:0] sel_mask;

   for (genvar k = 0; k < W; k++) begin : g_mask
      assign sel_mask[k] = (idx == IW'(k));
   end

   assign picked = |(val & sel_mask);

   always_comb begin
      unique case (mode)
         BM_SET:  out = val | sel_mask;
         BM_CLR:  out = val & ~sel_mask;
         default: out = val ^ sel_mask;
      endcase
   end
endmodule

// File: rtl/alu8_shl.sv
module alu8_shl #(
   parameter int W        = 8,
   parameter bit KEEP_LSB = 1'b0
) (
   input  logic [W-1:0] val,
   output logic [W-1:0] out,
   output logic         spill
);
   logic fill;

   if (KEEP_LSB) begin : g_keep
      assign fill = val[0];
   end else begin : g_zero
      assign fill = 1'b0;
   end

   assign out   = {val[W-2:0], fill};
   assign spill = val[W-1];
endmodule

// File: rtl/alu8_flagged.sv
module alu8_flagged
   import alu8_pkg::*;
#(
   parameter int W  = 8,
   parameter int IW = $clog2(W)
) (
   input  logic [OP_W-1:0] op_sel,
   input  logic [W-1:0]    src_a,
   input  logic [W-1:0]    src_b,
   input  logic [IW-1:0]   bit_sel,
   input  logic [W-1:0]    imm_val,
   input  logic            carry_in,
   output logic [W-1:0]    res,
   output logic            flag_z,
   output logic            flag_c,
   output logic            flag_t,
   output logic            wr_z,
   output logic            wr_c,
   output logic            wr_t
);
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
   localparam logic [W-1:0] ONES = {W{1'b1}};

   if (W < 2) begin : g_bad_w
      $error("alu8_flagged: W must be at least 2");
   end
   if ((1 << IW) < W) begin : g_bad_iw
      $error("alu8_flagged: IW too narrow for W");
   end

   alu_op_e   op;
   assign op = alu_op_e'(op_sel);

   // adder operand selection
   logic [W-1:0] ax, ay, asum;
   logic         acin, aneg, acout;

   always_comb begin
      ax   = src_a;
      ay   = src_b;
      acin = 1'b0;
      aneg = 1'b0;
      case (op)
         OP_ADC:  acin = carry_in;
         OP_SUB:  aneg = 1'b1;
         OP_SUC:  begin aneg = 1'b1; acin = carry_in; end
         OP_NEG:  begin ax = '0; ay = src_a; aneg = 1'b1; end
         OP_INC:  ay = ONE;
         OP_DEC:  ay = ONES;
         OP_ADI:  ay = imm_val;
         OP_SUI:  begin ay = imm_val; aneg = 1'b1; end
         default: ;
      endcase
   end

   alu8_addsub #(.W(W)) i_addsub (
      .x_in (ax),
      .y_in (ay),
      .cin  (acin),
      .neg_y(aneg),
      .sum  (asum),
      .cout (acout)
   );

   // bit manipulation
   bit_mode_e    bmode;
   logic [W-1:0] bout;
   logic         bpick;

   always_comb begin
      case (op)
         OP_BSET: bmode = BM_SET;
         OP_BCLR: bmode = BM_CLR;
         default: bmode = BM_FLIP;
      endcase
   end

   alu8_bitops #(.W(W), .IW(IW)) i_bitops (
      .val   (src_a),
      .idx   (bit_sel),
      .mode  (bmode),
      .out   (bout),
      .picked(bpick)
   );

   // shifts
   logic [W-1:0] sh0_out, shk_out;
   logic         sh0_msb, shk_msb;

   alu8_shl #(.W(W), .KEEP_LSB(1'b0)) i_shl0 (
      .val  (src_a),
      .out  (sh0_out),
      .spill(sh0_msb)
   );

   alu8_shl #(.W(W), .KEEP_LSB(1'b1)) i_shlk (
      .val  (src_a),
      .out  (shk_out),
      .spill(shk_msb)
   );

   // result and flag routing
   flag_en_t en;
   logic     c_val, t_val;

   always_comb begin
      res   = src_a;
      en    = '0;
      c_val = 1'b0;
      t_val = 1'b0;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SUC, OP_INC, OP_DEC, OP_ADI, OP_SUI: begin
            res   = asum;
            c_val = acout;
            en.z  = 1'b1;
            en.c  = 1'b1;
         end
         OP_NEG: begin
            res  = asum;
            en.z = 1'b1;
         end
         OP_OR:  begin res = src_a | src_b; en.z = 1'b1; end
         OP_AND: begin res = src_a & src_b; en.z = 1'b1; end
         OP_XOR: begin res = src_a ^ src_b; en.z = 1'b1; end
         OP_NOT: begin res = ~src_a;        en.z = 1'b1; end
         OP_TOL: begin res = (|src_a) ? ONE : '0; en.z = 1'b1; end
         OP_BSET, OP_BCLR, OP_BFLIP: begin
            res  = bout;
            en.z = 1'b1;
         end
         OP_BTEST: begin t_val = bpick;            en.t = 1'b1; end
         OP_EQU:   begin t_val = (src_a == src_b); en.t = 1'b1; end
         OP_SHL0: begin
            res   = sh0_out;
            c_val = sh0_msb;
            en.z  = 1'b1;
            en.c  = 1'b1;
         end
         OP_SHLK: begin
            res   = shk_out;
            c_val = shk_msb;
            en.z  = 1'b1;
            en.c  = 1'b1;
         end
         default: ;
      endcase
   end

   assign flag_z = ~|res;
   assign flag_c = c_val;
   assign flag_t = t_val;
   assign wr_z   = en.z;
   assign wr_c   = en.c;
   assign wr_t   = en.t;
endmodule

// File: rtl/alu8_flagged_chk.sv
module alu8_flagged_chk
   import alu8_pkg::*;
#(
   parameter int W  = 8,
   parameter int IW = $clog2(W)
) (
   input logic [OP_W-1:0] op_sel,
   input logic [W-1:0]    src_a,
   input logic [W-1:0]    src_b,
   input logic [IW-1:0]   bit_sel,
   input logic [W-1:0]    imm_val,
   input logic            carry_in,
   input logic [W-1:0]    res,
   input logic            flag_z,
   input logic            flag_c,
   input logic            flag_t,
   input logic            wr_z,
   input logic            wr_c,
   input logic            wr_t
);
   logic [W:0] add_ref;
   logic [W-1:0] and_ref;
   logic [W-1:0] neg_sum;

   always_comb begin
      add_ref = {1'b0, src_a} + {1'b0, src_b};
      and_ref = src_a & src_b;
      neg_sum = res + src_a;
      if (op_sel == OP_ADD) begin
         // R2
         add_sum_chk: assert ({flag_c, res} == add_ref && wr_c && wr_z && !wr_t);
      end
      if (op_sel == OP_NEG) begin
         // R6
         neg_only_z_chk: assert (neg_sum == '0 && wr_z && !wr_c && !wr_t);
      end
      if (op_sel == OP_AND) begin
         // R12
         and_zero_chk: assert (res == and_ref && flag_z == (and_ref == '0));
      end
      if (op_sel == OP_TOL) begin
         // R8
         tol_value_chk: assert (res == ((src_a != '0) ? W'(1) : W'(0)));
      end
      if (op_sel == OP_EQU) begin
         // R10
         equ_test_chk: assert (flag_t == (src_a == src_b) && wr_t && !wr_z && !wr_c);
      end
      if (op_sel == OP_SHL0) begin
         // R11
         shl_spill_chk: assert (flag_c == src_a[W-1] && res[0] == 1'b0);
      end
      if (op_sel > 5'd20) begin
         // R13
         unused_code_chk: assert (!wr_z && !wr_c && !wr_t && res == src_a);
      end
   end
endmodule

bind alu8_flagged alu8_flagged_chk #(.W(W), .IW(IW)) i_chk (
   .op_sel  (op_sel),
   .src_a   (src_a),
   .src_b   (src_b),
   .bit_sel (bit_sel),
   .imm_val (imm_val),
   .carry_in(carry_in),
   .res     (res),
   .flag_z  (flag_z),
   .flag_c  (flag_c),
   .flag_t  (flag_t),
   .wr_z    (wr_z),
   .wr_c    (wr_c),
   .wr_t    (wr_t)
);

// File: tb/test_alu8_flagged.sv
module test_alu8_flagged;
   logic       clk = 1'b0;
   logic [4:0] op_sel;
   logic [7:0] src_a, src_b, imm_val, res;
   logic [2:0] bit_sel;
   logic       carry_in, flag_z, flag_c, flag_t, wr_z, wr_c, wr_t;
   int         total = 0;
   int         bad = 0;

   always #2.5 clk = ~clk;

   alu8_flagged i_alu8_flagged (
      .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .bit_sel(bit_sel),
      .imm_val(imm_val), .carry_in(carry_in), .res(res),
      .flag_z(flag_z), .flag_c(flag_c), .flag_t(flag_t),
      .wr_z(wr_z), .wr_c(wr_c), .wr_t(wr_t)
   );

   function automatic string tag(input int op);
      case (op)
         0, 1:        return "R2";
         2, 3:        return "R3";
         4:           return "R6";
         5, 6:        return "R5";
         7, 8:        return "R4";
         9, 10, 11, 12: return "R7";
         13:          return "R8";
         14, 15, 16:  return "R9";
         17, 18:      return "R10";
         19, 20:      return "R11";
         default:     return "R13";
      endcase
   endfunction

   task automatic run(input int op, input int a, input int b, input int idx,
                      input int imm, input int cin);
      int r, s, ez, ec, et, z, c, t;
      @(negedge clk);
      op_sel = 5'(op); src_a = 8'(a); src_b = 8'(b);
      bit_sel = 3'(idx); imm_val = 8'(imm); carry_in = cin[0];
      #1;
      r = a; ez = 0; ec = 0; et = 0; c = 0; t = 0; s = 0;
      case (op)
         0:  s = a + b;
         1:  s = a + b + cin;
         2:  s = a + ((256 - b) % 256);
         3:  s = a + ((256 - b) % 256) + cin;
         5:  s = a + 1;
         6:  s = a + 255;
         7:  s = a + imm;
         8:  s = a + ((256 - imm) % 256);
         default: ;
      endcase
      if (op <= 8 && op != 4) begin
         r = s % 256; c = (s / 256) % 2; ez = 1; ec = 1;
      end
      case (op)
         4:  begin r = (256 - a) % 256; ez = 1; end
         9:  begin r = a | b; ez = 1; end
         10: begin r = a & b; ez = 1; end
         11: begin r = a ^ b; ez = 1; end
         12: begin r = 255 - a; ez = 1; end
         13: begin r = (a != 0) ? 1 : 0; ez = 1; end
         14: begin r = a | (1 << idx); ez = 1; end
         15: begin r = a & (255 - (1 << idx)); ez = 1; end
         16: begin r = a ^ (1 << idx); ez = 1; end
         17: begin t = (a >> idx) % 2; et = 1; end
         18: begin t = (a == b) ? 1 : 0; et = 1; end
         19: begin r = (a * 2) % 256; c = a / 128; ez = 1; ec = 1; end
         20: begin r = (a * 2) % 256 + a % 2; c = a / 128; ez = 1; ec = 1; end
         default: ;
      endcase
      z = (r == 0) ? 1 : 0;
      total++;
      if (int'(res) != r || int'(wr_z) != ez || int'(wr_c) != ec || int'(wr_t) != et ||
          (ez == 1 && int'(flag_z) != z) ||   // R12
          (ec == 1 && int'(flag_c) != c) ||
          (et == 1 && int'(flag_t) != t)) begin
         bad++;
         $display("FAIL %s op=%0d a=%02h b=%02h idx=%0d imm=%02h cin=%0d: got res=%02h z=%b c=%b t=%b we=%b%b%b exp res=%02h z=%0d c=%0d t=%0d we=%0d%0d%0d",
                  tag(op), op, a, b, idx, imm, cin, res, flag_z, flag_c, flag_t,
                  wr_z, wr_c, wr_t, r, z, c, t, ez, ec, et);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      op_sel = '0; src_a = '0; src_b = '0; bit_sel = '0; imm_val = '0; carry_in = 1'b0;
      void'($urandom(32'd4242));
      // R1 all-zero inputs: ADD of zeros gives zero result and Z
      run(0, 8'h00, 8'h00, 0, 0, 0);
      // R2 carry out with zero result
      run(0, 8'hff, 8'h01, 0, 0, 0);
      run(1, 8'hff, 8'h00, 0, 0, 1);
      run(1, 8'h10, 8'h20, 0, 0, 1);
      // R3 subtract zero, with and without incoming carry
      run(2, 8'h37, 8'h00, 0, 0, 0);
      run(3, 8'hff, 8'h00, 0, 0, 1);
      run(2, 8'h05, 8'h05, 0, 0, 0);
      run(3, 8'h05, 8'h06, 0, 0, 1);
      // R4 immediates
      run(7, 8'hf0, 8'h00, 0, 8'h10, 0);
      run(8, 8'h10, 8'h00, 0, 8'h10, 0);
      // R5 edge values
      run(5, 8'hff, 8'h00, 0, 0, 0);
      run(6, 8'h00, 8'h00, 0, 0, 0);
      run(6, 8'h01, 8'h00, 0, 0, 1);
      // R6 negate corners
      run(4, 8'h80, 8'h00, 0, 0, 1);
      run(4, 8'h00, 8'h00, 0, 0, 0);
      // R7 R8 logic and logical value
      run(12, 8'hff, 8'h00, 0, 0, 0);
      run(11, 8'h5a, 8'h5a, 0, 0, 0);
      run(13, 8'h00, 8'h00, 0, 0, 0);
      run(13, 8'h80, 8'h00, 0, 0, 0);
      // R9 clear last set bit, flip to zero
      run(15, 8'h40, 8'h00, 6, 0, 0);
      run(16, 8'h01, 8'h00, 0, 0, 0);
      run(14, 8'h00, 8'h00, 7, 0, 0);
      // R10 test and compare
      run(17, 8'h80, 8'h00, 7, 0, 0);
      run(17, 8'h7f, 8'h00, 7, 0, 1);
      run(18, 8'h33, 8'h33, 0, 0, 0);
      run(18, 8'h00, 8'h01, 0, 0, 1);
      // R11 shifts
      run(19, 8'h81, 8'h00, 0, 0, 0);
      run(20, 8'h81, 8'h00, 0, 0, 0);
      run(20, 8'h80, 8'h00, 0, 0, 0);
      // R13 unused codes
      run(21, 8'h00, 8'h12, 0, 0, 1);
      run(31, 8'ha5, 8'h00, 3, 0, 1);
      // random sweep over every code
      for (int n = 0; n < 1200; n++) begin
         run(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
             int'($urandom_range(0, 255)), int'($urandom_range(0, 7)),
             int'($urandom_range(0, 255)), int'($urandom_range(0, 1)));
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule